// File: doc/BRIEF.md
# Serial Flash Ready-Status Poller

This block sits on the host side of a serial NOR flash bus and waits for an operation inside the flash to finish. After a one-cycle start request it pulls chip select low, generates the serial clock, shifts out the opcode that reads the flag status byte, and then captures status bytes for as long as the flash stays busy. A single chip-select window may return many bytes. Polling stops when bit 7 of a returned byte is set. It also stops with an error once a programmable number of bytes has been read without that bit.

The command and the response can each use one, two or four data lines. In single-line mode, DQ0 always carries host data and DQ1 always carries flash data. In the wider modes, the host drives the lines for the opcode and then releases them so the flash can answer on the same lines.

Some completions must be confirmed on two dies. For these, the host can ask for a two-pass check: after the first ready byte, chip select goes high for a minimum number of system clocks, and a second read command follows. The result is reported only after the second pass also sees bit 7 set. The result is a one-cycle done pulse, the last status byte, and a timeout flag.

Top module: `flash_ready_poller`

## Requirements
- R1: Out of reset and while idle, chip select is high, the serial clock is low, no data line is driven (all output enables 0) and done is low.
- R2: Each chip-select window starts with opcode 8'h70 sent MSB first. Data lines change only while the serial clock is low, and both sides sample on its rising edge.
- R3: The mode input selects the line mode: 0 = single line, 1 = two lines, 2 or 3 = four lines. In single mode the opcode goes out on DQ0 and status comes back on DQ1, and DQ0 stays enabled for the whole window (enable 4'b0001). In two-line mode both opcode and status use DQ[1:0] (enable 4'b0011 during the opcode). In four-line mode both use DQ[3:0] (enable 4'b1111 during the opcode). In the two- and four-line modes all enables drop to 0 after the opcode.
- R4: The serial clock runs only while chip select is low, with one half period equal to CLK_HALF system clocks, and it is low whenever chip select is high.
- R5: Status bytes are assembled MSB first. Without leaving the chip-select window, the block keeps reading further bytes until one has bit 7 set.
- R6: In single-pass mode (two-pass input 0), the first byte with bit 7 set ends the operation. Chip select returns high, and done pulses with that byte on the status output and the timeout flag at 0.
- R7: In two-pass mode, the first ready byte closes the window. Chip select then stays high for at least CS_GAP system clocks before a second window with a fresh opcode. Done is reported only after the second window also returns a byte with bit 7 set, and the status output shows that byte.
- R8: The byte count runs across all windows of an operation. If it reaches the poll limit without a completing byte, the operation ends with chip select high, the timeout flag at 1 and the last byte on the status output. A limit of 0 acts as 1.
- R9: Done is a single-cycle pulse, issued once per accepted start. A start request that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin polling |
| mode_i | input | 2 | Line mode: 0 single, 1 two lines, 2/3 four lines |
| two_pass_i | input | 1 | Require two agreeing windows before done |
| poll_limit_i | input | LIMIT_W | Maximum number of status bytes per operation |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Operation ended by the poll limit (valid with done) |
| status_o | output | 8 | Last status byte captured (valid with done) |
| csn_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| dq_o | output | 4 | Host data toward the flash |
| dq_oe_o | output | 4 | Per-line output enable for dq_o |
| dq_i | input | 4 | Data lines as seen from the flash |

## Verification
A wrong beat counter or lane selection corrupts the captured byte, so status_o differs from the sent pattern as soon as done pulses, within one byte time. A wrong state after the opcode shows up at the next rising serial clock edge as an output enable still set on lines the flash is driving. A bad pass or limit register shows at the ports within one operation as an extra or missing chip-select window, a count of bytes read that does not match, or a timeout flag with the wrong value. A counted gap shorter than CS_GAP between the two windows is visible as soon as chip select falls for the second time.

// File: rtl/frp_pkg.sv
package frp_pkg;

  localparam logic [7:0] POLL_OPCODE = 8'h70;

  localparam logic [1:0] LANE_X1 = 2'd0;
  localparam logic [1:0] LANE_X2 = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_TURN, ST_DATA, ST_DRAIN, ST_GAP, ST_DONE
  } poll_state_e;

  // index of the last rising edge inside one byte
  function automatic logic [2:0] last_beat(input logic [1:0] m);
    case (m)
      LANE_X1: return 3'd7;
      LANE_X2: return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  // lanes presented on DQ for the current top bits of the byte
  function automatic logic [3:0] tx_lanes(input logic [7:0] b, input logic [1:0] m);
    case (m)
      LANE_X1: return {3'b000, b[7]};
      LANE_X2: return {2'b00, b[7:6]};
      default: return b[7:4];
    endcase
  endfunction

  function automatic logic [7:0] tx_shift(input logic [7:0] b, input logic [1:0] m);
    case (m)
      LANE_X1: return {b[6:0], 1'b0};
      LANE_X2: return {b[5:0], 2'b00};
      default: return {b[3:0], 4'b0000};
    endcase
  endfunction

  function automatic logic [7:0] rx_shift(input logic [7:0] b, input logic [3:0] dq,
                                          input logic [1:0] m);
    case (m)
      LANE_X1: return {b[6:0], dq[1]};
      LANE_X2: return {b[5:0], dq[1:0]};
      default: return {b[3:0], dq};
    endcase
  endfunction

  function automatic logic [3:0] cmd_oe(input logic [1:0] m);
    case (m)
      LANE_X1: return 4'b0001;
      LANE_X2: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [3:0] data_oe(input logic [1:0] m);
    return (m == LANE_X1) ? 4'b0001 : 4'b0000;
  endfunction

  function automatic logic poll_spent(input int unsigned used, input int unsigned lim);
    return (lim == 0) ? 1'b1 : (used >= lim);
  endfunction

endpackage

// File: rtl/frp_sclk_gen.sv
module frp_sclk_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          edge_w;

  assign edge_w = run_i && (cnt_q == CW'(HALF_CYC - 1));
  assign rise_o = edge_w && !sclk_o;
  assign fall_o = edge_w && sclk_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (edge_w) begin
      cnt_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_clk_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $past(run_i));

endmodule

// File: rtl/frp_lane_shifter.sv
module frp_lane_shifter
  import frp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       load_i,
  input  logic       adv_i,
  input  logic       cap_i,
  input  logic [3:0] dq_i,
  output logic [3:0] tx_lanes_o,
  output logic [7:0] rx_next_o
);
  logic [7:0] tx_q;
  logic [7:0] rx_q;

  assign tx_lanes_o = tx_lanes(tx_q, mode_i);
  assign rx_next_o  = rx_shift(rx_q, dq_i, mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)     tx_q <= POLL_OPCODE;
      else if (adv_i) tx_q <= tx_shift(tx_q, mode_i);
      if (cap_i)      rx_q <= rx_next_o;
    end
  end

endmodule

// File: rtl/frp_ctrl.sv
module frp_ctrl
  import frp_pkg::*;
#(
  parameter int CS_GAP  = 4,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic               two_pass_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic [7:0]         rx_next_i,
  output logic [1:0]         mode_o,
  output logic               run_o,
  output logic               load_o,
  output logic               adv_o,
  output logic               cap_o,
  output logic               drive_o,
  output logic               data_phase_o,
  output logic               second_pass_o,
  output logic               csn_o,
  output logic [3:0]         oe_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic [7:0]         status_o
);
  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP + 1) : 1;

  poll_state_e        state_q;
  logic [1:0]         mode_q;
  logic               two_pass_q;
  logic [LIMIT_W-1:0] limit_q;
  logic [LIMIT_W-1:0] polls_q;
  logic [2:0]         beat_q;
  logic               pass_q;
  logic               to_gap_q;
  logic [GW-1:0]      gap_q;
  logic [7:0]         status_q;
  logic               timeout_q;

  logic byte_end;
  logic spent;
  logic gap_end;

  assign run_o         = state_q inside {ST_CMD, ST_TURN, ST_DATA, ST_DRAIN};
  assign csn_o         = !run_o;
  assign drive_o       = state_q inside {ST_CMD, ST_TURN};
  assign data_phase_o  = state_q inside {ST_DATA, ST_DRAIN};
  assign gap_end       = (gap_q == GW'(CS_GAP - 1));
  assign load_o        = (state_q == ST_IDLE && start_i) || (state_q == ST_GAP && gap_end);
  assign adv_o         = (state_q == ST_CMD) && fall_i;
  assign cap_o         = (state_q == ST_DATA) && rise_i;
  assign byte_end      = cap_o && (beat_q == last_beat(mode_q));
  assign spent         = poll_spent(32'(polls_q) + 32'd1, 32'(limit_q));
  assign oe_o          = drive_o ? cmd_oe(mode_q) : (data_phase_o ? data_oe(mode_q) : 4'b0000);
  assign mode_o        = mode_q;
  assign second_pass_o = pass_q;
  assign done_o        = (state_q == ST_DONE);
  assign timeout_o     = timeout_q;
  assign status_o      = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= LANE_X1;
      two_pass_q <= 1'b0;
      limit_q    <= '0;
      polls_q    <= '0;
      beat_q     <= '0;
      pass_q     <= 1'b0;
      to_gap_q   <= 1'b0;
      gap_q      <= '0;
      status_q   <= '0;
      timeout_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q     <= mode_i;
          two_pass_q <= two_pass_i;
          limit_q    <= limit_i;
          polls_q    <= '0;
          beat_q     <= '0;
          pass_q     <= 1'b0;
          timeout_q  <= 1'b0;
          state_q    <= ST_CMD;
        end
        ST_CMD: if (rise_i) begin
          if (beat_q == last_beat(mode_q)) begin
            beat_q  <= '0;
            state_q <= ST_TURN;
          end else begin
            beat_q <= beat_q + 3'd1;
          end
        end
        ST_TURN: if (fall_i) state_q <= ST_DATA;
        ST_DATA: if (cap_o) begin
          if (byte_end) begin
            beat_q   <= '0;
            polls_q  <= polls_q + 1'b1;
            status_q <= rx_next_i;
            if (rx_next_i[7]) begin
              to_gap_q <= two_pass_q && !pass_q;
              pass_q   <= 1'b1;
              state_q  <= ST_DRAIN;
            end else if (spent) begin
              timeout_q <= 1'b1;
              to_gap_q  <= 1'b0;
              state_q   <= ST_DRAIN;
            end
          end else begin
            beat_q <= beat_q + 3'd1;
          end
        end
        ST_DRAIN: if (fall_i) begin
          gap_q   <= '0;
          state_q <= to_gap_q ? ST_GAP : ST_DONE;
        end
        ST_GAP: begin
          if (gap_end) begin
            beat_q  <= '0;
            state_q <= ST_CMD;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_ready_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !timeout_o) |-> status_o[7]);

  p_timeout_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && timeout_o) |-> !status_o[7]);

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn_o && !$rose(run_o)) |-> $stable(mode_q));

endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
  import frp_pkg::*;
#(
  parameter int CLK_HALF = 2,
  parameter int CS_GAP   = 4,
  parameter int LIMIT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic               two_pass_i,
  input  logic [LIMIT_W-1:0] poll_limit_i,
  output logic               done_o,
  output logic               timeout_o,
  output logic [7:0]         status_o,
  output logic               csn_o,
  output logic               sclk_o,
  output logic [3:0]         dq_o,
  output logic [3:0]         dq_oe_o,
  input  logic [3:0]         dq_i
);
  logic       run_w, rise_w, fall_w;
  logic       load_w, adv_w, cap_w, drive_w;
  logic       data_phase_w, second_pass_w;
  logic [1:0] mode_w;
  logic [3:0] tx_lanes_w;
  logic [7:0] rx_next_w;

  frp_sclk_gen #(.HALF_CYC(CLK_HALF)) i_sclk (
    .clk(clk), .rst_n(rst_n), .run_i(run_w),
    .sclk_o(sclk_o), .rise_o(rise_w), .fall_o(fall_w)
  );

  frp_lane_shifter i_shift (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_w),
    .load_i(load_w), .adv_i(adv_w), .cap_i(cap_w), .dq_i(dq_i),
    .tx_lanes_o(tx_lanes_w), .rx_next_o(rx_next_w)
  );

  frp_ctrl #(.CS_GAP(CS_GAP), .LIMIT_W(LIMIT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .two_pass_i(two_pass_i), .limit_i(poll_limit_i),
    .rise_i(rise_w), .fall_i(fall_w), .rx_next_i(rx_next_w),
    .mode_o(mode_w), .run_o(run_w), .load_o(load_w), .adv_o(adv_w),
    .cap_o(cap_w), .drive_o(drive_w), .data_phase_o(data_phase_w),
    .second_pass_o(second_pass_w), .csn_o(csn_o), .oe_o(dq_oe_o),
    .done_o(done_o), .timeout_o(timeout_o), .status_o(status_o)
  );

  assign dq_o = drive_w ? tx_lanes_w : 4'b0000;

  // checker-side count of consecutive high chip-select cycles
  logic [15:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_run_q <= '0;
    else if (!csn_o)                     hi_run_q <= '0;
    else if (hi_run_q != 16'hFFFF)       hi_run_q <= hi_run_q + 16'd1;
  end

  p_cs_parks_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csn_o |-> (!sclk_o && dq_oe_o == 4'b0000));

  p_dq_settled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(dq_o));

  p_data_turnaround_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase_w && mode_w != LANE_X1) |-> (dq_oe_o == 4'b0000));

  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(csn_o) && second_pass_w) |-> (hi_run_q >= 16'(CS_GAP)));

endmodule

// File: tb/test_flash_ready_poller.sv
module test_flash_ready_poller;
  localparam int CS_GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        two_pass_i = 1'b0;
  logic [15:0] poll_limit_i = 16'd0;
  logic        done_o, timeout_o, csn_o, sclk_o;
  logic [7:0]  status_o;
  logic [3:0]  dq_o, dq_oe_o;
  logic [3:0]  dq_i = 4'b0000;

  always #10 clk = ~clk;

  flash_ready_poller #(.CLK_HALF(2), .CS_GAP(CS_GAP), .LIMIT_W(16)) i_flash_ready_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .two_pass_i(two_pass_i), .poll_limit_i(poll_limit_i),
    .done_o(done_o), .timeout_o(timeout_o), .status_o(status_o),
    .csn_o(csn_o), .sclk_o(sclk_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i)
  );

  int checks = 0;
  int errors = 0;

  // flash-side model state
  logic [7:0] resp [0:15];
  int m_mode = 0;
  int windows = 0, rd_cnt = 0, rx_bits = 0, cmd_bits = 0;
  int opc_ok = 0, oe_bad = 0, last_gap = 0, hi_cnt = 0, done_cnt = 0;
  logic [7:0] cmd_sh = 8'h00;

  function automatic int lanes_of(input int m);
    return (m == 0) ? 1 : ((m == 1) ? 2 : 4);
  endfunction

  always @(negedge csn_o) begin
    windows  = windows + 1;
    cmd_bits = 0;
    cmd_sh   = 8'h00;
    rx_bits  = 0;
  end

  always @(posedge clk) begin
    if (csn_o) hi_cnt = hi_cnt + 1;
    else begin
      if (hi_cnt != 0) last_gap = hi_cnt;
      hi_cnt = 0;
    end
    if (done_o) done_cnt = done_cnt + 1;
  end

  always @(posedge sclk_o) begin
    if (!csn_o) begin
      if (cmd_bits < 8) begin
        case (m_mode)
          0: cmd_sh = {cmd_sh[6:0], dq_o[0]};
          1: cmd_sh = {cmd_sh[5:0], dq_o[1:0]};
          default: cmd_sh = {cmd_sh[3:0], dq_o};
        endcase
        if (dq_oe_o != ((m_mode == 0) ? 4'b0001 : (m_mode == 1) ? 4'b0011 : 4'b1111))
          oe_bad = oe_bad + 1;
        cmd_bits = cmd_bits + lanes_of(m_mode);
        if (cmd_bits == 8 && cmd_sh == 8'h70) opc_ok = opc_ok + 1;
      end else begin
        if (dq_oe_o != ((m_mode == 0) ? 4'b0001 : 4'b0000)) oe_bad = oe_bad + 1;
        rx_bits = rx_bits + lanes_of(m_mode);
        if (rx_bits == 8) begin
          rx_bits = 0;
          rd_cnt  = rd_cnt + 1;
        end
      end
    end
  end

  always @(negedge sclk_o) begin
    if (!csn_o && cmd_bits >= 8) begin
      logic [7:0] cur;
      #1;
      cur = resp[rd_cnt % 16];
      case (m_mode)
        0: dq_i = {2'b00, cur[7 - rx_bits], 1'b0};
        1: dq_i = {2'b00, cur[7 - rx_bits -: 2]};
        default: dq_i = cur[7 - rx_bits -: 4];
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lo);
    checks = checks + 1;
    if (act < lo) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lo);
    end
  endtask

  task automatic clear_resp();
    for (int i = 0; i < 16; i++) resp[i] = 8'h00;
  endtask

  // launch one operation and wait for done; returns status and timeout seen with done
  task automatic run_op(input int m, input bit tp, input int lim,
                        output logic [7:0] st, output logic to);
    int n;
    m_mode = m; windows = 0; rd_cnt = 0; opc_ok = 0; oe_bad = 0; done_cnt = 0;
    @(negedge clk);
    mode_i = 2'(m); two_pass_i = tp; poll_limit_i = 16'(lim); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R9 done seen", int'(done_o), 1);
    st = status_o;
    to = timeout_o;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 csn idle", int'(csn_o), 1);
    chk("R1 sclk idle", int'(sclk_o), 0);
    chk("R1 oe idle", int'(dq_oe_o), 0);
    chk("R1 done idle", int'(done_o), 0);
  endtask

  task automatic t_single_ready();
    logic [7:0] st; logic to;
    clear_resp(); resp[0] = 8'h81;
    run_op(0, 1'b0, 10, st, to);
    chk("R6 status", int'(st), 8'h81);
    chk("R6 timeout", int'(to), 0);
    chk("R6 csn back high", int'(csn_o), 1);
    chk("R2 opcode", opc_ok, 1);
    chk("R3 single lanes", oe_bad, 0);
    chk("R9 one done", done_cnt, 1);
  endtask

  task automatic t_single_busy();
    logic [7:0] st; logic to;
    clear_resp(); resp[0] = 8'h00; resp[1] = 8'h01; resp[2] = 8'h42; resp[3] = 8'h84;
    run_op(0, 1'b0, 10, st, to);
    chk("R5 status", int'(st), 8'h84);
    chk("R5 bytes read", rd_cnt, 4);
    chk("R5 one window", windows, 1);
  endtask

  task automatic t_dual();
    logic [7:0] st; logic to;
    clear_resp(); resp[0] = 8'h10; resp[1] = 8'hA5;
    run_op(1, 1'b0, 10, st, to);
    chk("R3 dual status", int'(st), 8'hA5);
    chk("R3 dual bytes", rd_cnt, 2);
    chk("R3 dual turnaround", oe_bad, 0);
    chk("R2 dual opcode", opc_ok, 1);
  endtask

  task automatic t_quad();
    logic [7:0] st; logic to;
    clear_resp(); resp[0] = 8'h00; resp[1] = 8'h3E; resp[2] = 8'hC3;
    run_op(2, 1'b0, 10, st, to);
    chk("R3 quad status", int'(st), 8'hC3);
    chk("R3 quad bytes", rd_cnt, 3);
    chk("R3 quad turnaround", oe_bad, 0);
    chk("R2 quad opcode", opc_ok, 1);
  endtask

  task automatic t_two_pass_single();
    logic [7:0] st; logic to;
    clear_resp(); resp[0] = 8'h80; resp[1] = 8'h81;
    run_op(0, 1'b1, 10, st, to);
    chk("R7 windows", windows, 2);
    chk_ge("R7 gap", last_gap, CS_GAP);
    chk("R7 bytes", rd_cnt, 2);
    chk("R7 status", int'(st), 8'h81);
    chk("R7 opcode per window", opc_ok, 2);
  endtask

  task automatic t_two_pass_quad();
    logic [7:0] st; logic to;
    clear_resp(); resp[0] = 8'h00; resp[1] = 8'h90; resp[2] = 8'h01; resp[3] = 8'h82;
    run_op(2, 1'b1, 10, st, to);
    chk("R7 quad windows", windows, 2);
    chk("R7 quad bytes", rd_cnt, 4);
    chk("R7 quad status", int'(st), 8'h82);
    chk("R7 quad timeout", int'(to), 0);
  endtask

  task automatic t_timeout();
    logic [7:0] st; logic to;
    clear_resp(); resp[3] = 8'h11; resp[4] = 8'h3C;
    run_op(1, 1'b0, 5, st, to);
    chk("R8 timeout", int'(to), 1);
    chk("R8 bytes", rd_cnt, 5);
    chk("R8 last status", int'(st), 8'h3C);
    chk("R8 csn high", int'(csn_o), 1);
    chk("R8 windows", windows, 1);
  endtask

  task automatic t_limit_zero();
    logic [7:0] st; logic to;
    clear_resp(); resp[0] = 8'h05;
    run_op(2, 1'b0, 0, st, to);
    chk("R8 zero limit timeout", int'(to), 1);
    chk("R8 zero limit bytes", rd_cnt, 1);
  endtask

  task automatic t_busy_start();
    int n;
    clear_resp(); resp[0] = 8'h00; resp[1] = 8'h00; resp[2] = 8'h80;
    m_mode = 0; windows = 0; rd_cnt = 0; opc_ok = 0; oe_bad = 0; done_cnt = 0;
    @(negedge clk);
    mode_i = 2'd0; two_pass_i = 1'b0; poll_limit_i = 16'd10; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    mode_i = 2'd2; two_pass_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R9 busy status", int'(status_o), 8'h80);
    repeat (20) @(negedge clk);
    chk("R9 busy windows", windows, 1);
    chk("R9 busy done count", done_cnt, 1);
    chk("R9 busy bytes", rd_cnt, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_resp();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single_ready();
    t_single_busy();
    t_dual();
    t_quad();
    t_two_pass_single();
    t_two_pass_quad();
    t_timeout();
    t_limit_zero();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule